// File: doc/BRIEF.md
# One-Shot Prescaled Delay Timer

The block measures one programmable delay and then stops. Software picks one of four coarse timebases in a control/status register and writes a tick count to a separate preload register. That write starts the countdown. When the last tick has elapsed, an expiry flag sets and the timer halts, with no reload. A read of the control/status register clears the flag. An enable bit in the same register lets the flag drive an interrupt line.

A typical use is a glitch filter on a slow input. Software clears its own edge latch and starts a delay as long as the longest period it will accept. It waits for expiry and then checks whether another edge arrived during the delay. A short delay (7 ticks of the finest base) and a long delay (88 ticks of the third base) cover both line-rate and frame-rate signals.

Top module: `oneshot_delay_timer`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, the preload register (address 1) reads 0x00 and irq_o is low.
- R2: Control/status layout: bits 7:6 are the timebase select, bit 5 is the expiry flag (read-only), bit 4 is the interrupt enable, and bits 3:0 always read 0 and ignore writes. The preload register reads back the last value written.
- R3: Timebase select 00, 01, 10 and 11 give one tick every 128, 512, 2048 and 8192 clocks.
- R4: A nonzero preload write of N starts the countdown and restarts the prescaler. The expiry flag is visible exactly N times the tick period in clocks after the clock edge that took the write.
- R5: After expiry the timer stays stopped. Once the flag is cleared, it does not set again unless a new preload write is made.
- R6: A read of address 0 clears the expiry flag. A read of address 1 and any write to address 0 leave the flag unchanged.
- R7: If expiry and a clearing read of address 0 happen at the same clock edge, the flag stays set.
- R8: irq_o is high exactly while both the expiry flag and the interrupt enable are set.
- R9: A preload write during a countdown restarts it from the new value, timed from that write.
- R10: The timebase is captured when the countdown starts. Changing the select during a countdown does not alter that delay.
- R11: A preload write of 0 stops any running countdown and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 control/status, 1 preload |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; a read of address 0 clears the flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Expiry interrupt, gated by the enable bit |

## Verification
The bench times each expiry to the exact clock by watching irq_o, on all four timebases. A prescaler that is not restarted on the preload write, or that is off by one, shows up as a delay one clock or one tick away from the expected value. A clearing read is placed on the very edge of an expiry; a design that lets the clear win would lose that event. Further tests change the timebase select part way through a delay, rewrite the preload during a countdown, and write a zero preload. These catch designs that use the live select, keep the old count, or fire on a zero count. The bench also watches for a second expiry after the first and checks that a control write does not clear the flag, which catches a timer that reloads or a flag bit that can be written.

// File: rtl/odt_pkg.sv
package odt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_TB   = 1 << SEL_W;

  // control/status bit positions, decoded by software
  localparam int unsigned SEL_LSB  = 6;
  localparam int unsigned FLAG_BIT = 5;
  localparam int unsigned IEN_BIT  = 4;

  localparam logic ADDR_CTRL    = 1'b0;
  localparam logic ADDR_PRELOAD = 1'b1;

  typedef struct packed {
    logic [SEL_W-1:0] tb_sel;
    logic             irq_en;
  } ctrl_t;

  function automatic int unsigned max_shift(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/odt_prescaler.sv
module odt_prescaler
  import odt_pkg::*;
#(
  parameter int unsigned SH0 = 7,
  parameter int unsigned SH1 = 9,
  parameter int unsigned SH2 = 11,
  parameter int unsigned SH3 = 13,
  parameter int unsigned PW  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned SHIFTS [N_TB] = '{SH0, SH1, SH2, SH3};

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim [N_TB];

  for (genvar g = 0; g < N_TB; g++) begin : g_lim
    assign lim[g] = PW'((64'd1 << SHIFTS[g]) - 64'd1);
  end

  assign tick_o = run_i && !restart_i && (cnt_q == lim[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (restart_i || !run_i)     cnt_q <= '0;
    else if (tick_o)                  cnt_q <= '0;
    else                              cnt_q <= cnt_q + PW'(1);
  end

  a_r4_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  a_r3_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/odt_countdown.sv
module odt_countdown
  import odt_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CW-1:0]    load_val_i,
  input  logic [SEL_W-1:0] tb_sel_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             run_o,
  output logic [SEL_W-1:0] tb_run_o,
  output logic             expire_o,
  output logic             flag_o
);
  logic [CW-1:0]    cnt_q;
  logic             run_q, flag_q;
  logic [SEL_W-1:0] tb_q;

  assign expire_o = run_q && tick_i && !load_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tb_q  <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= (load_val_i != '0);
      tb_q  <= tb_sel_i;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) run_q <= 1'b0;
    end
  end

  // expiry wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_o) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign run_o    = run_q;
  assign tb_run_o = tb_q;
  assign flag_o   = flag_q;

  a_r4_set_on_last_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i && cnt_q == CW'(1)));
  a_r5_stopped_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> !run_q);
  a_r10_tb_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !load_i |=> $stable(tb_q));
  a_r11_zero_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && load_val_i == '0 |=> !run_q);
endmodule

// File: rtl/odt_regs.sv
module odt_regs
  import odt_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CW-1:0]     load_val_o,
  output logic              clr_o,
  output logic [SEL_W-1:0]  tb_sel_o,
  output logic              irq_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] pre_q;
  logic          wr_ctrl;

  assign wr_ctrl    = wr_en_i && (addr_i == ADDR_CTRL);
  assign load_o     = wr_en_i && (addr_i == ADDR_PRELOAD);
  assign load_val_o = wdata_i[CW-1:0];
  assign clr_o      = rd_en_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.tb_sel <= wdata_i[SEL_LSB +: SEL_W];
        ctrl_q.irq_en <= wdata_i[IEN_BIT];
      end
      if (load_o) pre_q <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[SEL_LSB +: SEL_W] = ctrl_q.tb_sel;
      rdata_o[FLAG_BIT]         = flag_i;
      rdata_o[IEN_BIT]          = ctrl_q.irq_en;
    end else begin
      rdata_o[CW-1:0] = pre_q;
    end
  end

  assign tb_sel_o = ctrl_q.tb_sel;
  assign irq_o    = flag_i && ctrl_q.irq_en;

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o && !expire_i |=> !flag_i);
  a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o && expire_i |=> flag_i);
  a_r6_ctrl_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !expire_i |=> flag_i == $past(flag_i));
endmodule

// File: rtl/oneshot_delay_timer.sv
module oneshot_delay_timer
  import odt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TB_SH0 = 7,
  parameter int unsigned TB_SH1 = 9,
  parameter int unsigned TB_SH2 = 11,
  parameter int unsigned TB_SH3 = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PW = max_shift(TB_SH0, TB_SH1, TB_SH2, TB_SH3);

  logic             load, clr, tick, run, expire, flag;
  logic [CNT_W-1:0] load_val;
  logic [SEL_W-1:0] tb_sel, tb_run;

  odt_regs #(.CW(CNT_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .flag_i(flag), .expire_i(expire), .rdata_o,
    .load_o(load), .load_val_o(load_val), .clr_o(clr),
    .tb_sel_o(tb_sel), .irq_o
  );

  odt_countdown #(.CW(CNT_W)) i_count (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .tb_sel_i(tb_sel), .tick_i(tick), .clr_i(clr),
    .run_o(run), .tb_run_o(tb_run), .expire_o(expire), .flag_o(flag)
  );

  odt_prescaler #(
    .SH0(TB_SH0), .SH1(TB_SH1), .SH2(TB_SH2), .SH3(TB_SH3), .PW(PW)
  ) i_presc (
    .clk_i, .rst_ni, .restart_i(load), .run_i(run),
    .sel_i(tb_run), .tick_o(tick)
  );

  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rdata_o[FLAG_BIT] || addr_i != ADDR_CTRL);
endmodule

// File: tb/test_oneshot_delay_timer.sv
`timescale 1ns/1ps
module test_oneshot_delay_timer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  oneshot_delay_timer i_oneshot_delay_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // counts clocks until irq_o rises; offset = clocks already spent since the start edge
  task automatic measure(input string tag, input int offset, input int exp);
    int n = offset;
    while (!irq && n < exp + 64) begin @(negedge clk); n++; end
    chk(tag, n, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", int'(irq), 0);
    rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
    rd(1'b1, d); chk("R1 preload", d, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(1'b0, 8'hCF); rd(1'b0, d); chk("R2 ctrl readback", d, 8'hC0);
    wr(1'b1, 8'h5A); rd(1'b1, d); chk("R2 preload readback", d, 8'h5A);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_timebases();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      int n = (s == 0) ? 3 : (s == 1) ? 2 : 1;
      wr(1'b0, 8'((s << 6) | 8'h10));
      wr(1'b1, 8'(n));
      measure($sformatf("R3 R4 delay sel=%0d", s), 0, n * (128 << (2 * s)));
      rd(1'b0, d);
      chk("R6 flag clear", int'(irq), 0);
    end
  endtask

  task automatic t_noirq_and_clear();
    logic [7:0] d;
    wr(1'b0, 8'h00); wr(1'b1, 8'd1);
    repeat (130) @(negedge clk);
    chk("R8 irq gated", int'(irq), 0);
    rd(1'b1, d);
    wr(1'b0, 8'h1F);
    chk("R6 R8 flag kept", int'(irq), 1);
    rd(1'b0, d); chk("R2 R6 status", d, 8'h30);
    chk("R6 cleared", int'(irq), 0);
    repeat (400) @(negedge clk);
    chk("R5 no rerun irq", int'(irq), 0);
    rd(1'b0, d); chk("R5 status", d, 8'h10);
  endtask

  task automatic t_clear_race();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'd1);
    repeat (126) @(negedge clk);
    rd(1'b0, d);
    chk("R7 flag survives", int'(irq), 1);
    rd(1'b0, d); chk("R7 status", d, 8'h30);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'd4);
    repeat (200) @(negedge clk);
    wr(1'b1, 8'd1);
    measure("R9 restart", 0, 128);
    rd(1'b0, d);
  endtask

  task automatic t_sel_change();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'd2);
    repeat (50) @(negedge clk);
    wr(1'b0, 8'hD0);
    measure("R10 base held", 52, 256);
    rd(1'b0, d);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'd3);
    repeat (100) @(negedge clk);
    wr(1'b1, 8'd0);
    repeat (600) @(negedge clk);
    chk("R11 zero stops", int'(irq), 0);
    rd(1'b0, d); chk("R11 status", d, 8'h10);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_timebases();
    t_noirq_and_clear();
    t_clear_race();
    t_restart();
    t_sel_change();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule